// File: doc/BRIEF.md
# Two-Beat Burst Synchronous SRAM with Byte Masks

This block is a synchronous memory model that moves data only in fixed bursts of two words. A controller puts a transfer on a shared address bus by pulling a load strobe low on a command edge. It chooses the direction with a single read/write input. The low bit of the loaded address seeds a one-bit linear burst counter. The counter picks the second word of the pair, wrapping inside the aligned pair.

One beat clock at twice the command rate stands in for the true and complementary input clocks. An internal phase bit splits its rising edges into command edges and second-beat edges. Write data, with an active-low select per byte, is taken on two consecutive edges one command cycle after the write command. Read data comes back on two consecutive edges one command cycle after the read command. The read output bus floats whenever no read beat is in flight. Back-to-back commands keep both pipelines busy with no gap. A read issued directly after a write to the same pair sees the new data.

Top module: `burst2_sram`

## Requirements
- R1: While `rst_n` is low and after it rises, `q_drive` is 0 and `q` is not driven. The third rising edge of `clk` after `rst_n` rises is the first command edge. From then on, command edges and second-beat edges alternate.
- R2: `load_n` is sampled only on command edges. Any level of `load_n`, `rd_wr` and `addr` at a second-beat edge starts no transfer and changes no memory word.
- R3: When `load_n` is low on a command edge, `rd_wr` = 1 starts a read and `rd_wr` = 0 starts a write of the loaded address.
- R4: Every transfer is two words. Beat 0 uses address `addr`. Beat 1 uses `addr` with bit 0 advanced by one, wrapping within the aligned pair (1 becomes 0).
- R5: Write beat 0 data is taken from `d` on the next command edge after the write command. Beat 1 is taken on the second-beat edge that follows.
- R6: `bw_n[i]` is active low and covers `d[i*BYTE_W +: BYTE_W]` (default: bit 0 covers bits 8:0, bit 1 covers bits 17:9). It is sampled on the same edge as its data beat. A high select leaves that byte of the memory word unchanged.
- R7: For a read command on command edge E, beat 0 is on `q` from edge E+2 to E+3 and beat 1 from E+3 to E+4, with `q_drive` high during both.
- R8: When no read beat is in flight, `q_drive` is 0 and `q` is high impedance. This includes the two beats that follow a write command.
- R9: Commands on consecutive command edges are served with no gap. A read of a pair written by the immediately preceding command returns the newly written, byte-merged data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, two rising edges per command cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low transfer strobe, sampled on command edges |
| rd_wr | input | 1 | Direction: 1 read, 0 write |
| addr | input | ADDR_W | Word address; bit 0 seeds the burst counter |
| d | input | WORD_W | Write data, one word per beat |
| bw_n | input | WORD_W/BYTE_W | Active-low byte write selects, one per beat |
| q | output | WORD_W | Read data, high impedance when idle |
| q_drive | output | 1 | High while `q` carries a read beat |

## Verification
The hardest case to reach is a command-edge event that overlaps a beat of the earlier command. For example, a read is loaded in the same cycle that the preceding write's data lands in the same pair. Junk strobes also arrive on second-beat edges while a burst is under way. The bench drives every cycle through one task. That task carries the previous command's data beats alongside the new command and puts random strobe, direction and address values on every second-beat edge. A long random run mixes reads, writes and masks over the whole array, so these overlaps happen many times. A mask sweep then pairs every beat-0 and beat-1 select pattern with an immediate read-back of the same pair.

// File: rtl/burst2_pkg.sv
package burst2_pkg;
  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } dir_e;
endpackage

// File: rtl/b2_cmd_pipe.sv
module b2_cmd_pipe import burst2_pkg::*; #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              phase,
  output logic              beat_vld,
  output logic              beat_rd,
  output logic [ADDR_W-1:0] beat_addr
);
  logic              phase_q, phase_d;
  logic              cmd_vld_q, cmd_vld_d, act_vld_q, act_vld_d;
  logic              cmd_rd_q, cmd_rd_d, act_rd_q, act_rd_d;
  logic [ADDR_W-1:0] cmd_addr_q, cmd_addr_d, act_addr_q, act_addr_d;
  logic              cmd_en;
  logic              sel_vld, sel_rd;
  logic [ADDR_W-1:0] sel_addr;
  logic              burst_lsb;

  assign cmd_en = ~phase_q;

  always_comb begin
    phase_d    = ~phase_q;
    cmd_vld_d  = cmd_vld_q;
    cmd_rd_d   = cmd_rd_q;
    cmd_addr_d = cmd_addr_q;
    act_vld_d  = act_vld_q;
    act_rd_d   = act_rd_q;
    act_addr_d = act_addr_q;
    if (cmd_en) begin
      cmd_vld_d  = ~load_n;
      cmd_rd_d   = (dir_e'(rd_wr) == DIR_READ);
      cmd_addr_d = addr;
      act_vld_d  = cmd_vld_q;
      act_rd_d   = cmd_rd_q;
      act_addr_d = cmd_addr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= 1'b0;
      cmd_vld_q <= 1'b0;
      act_vld_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      cmd_vld_q <= cmd_vld_d;
      act_vld_q <= act_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    cmd_rd_q   <= cmd_rd_d;
    cmd_addr_q <= cmd_addr_d;
    act_rd_q   <= act_rd_d;
    act_addr_q <= act_addr_d;
  end

  // Beat 0 runs from the pending command, beat 1 from the copy taken at beat 0.
  assign sel_vld   = phase_q ? act_vld_q  : cmd_vld_q;
  assign sel_rd    = phase_q ? act_rd_q   : cmd_rd_q;
  assign sel_addr  = phase_q ? act_addr_q : cmd_addr_q;
  assign burst_lsb = sel_addr[0] + phase_q;

  assign phase     = phase_q;
  assign beat_vld  = sel_vld;
  assign beat_rd   = sel_rd;
  assign beat_addr = {sel_addr[ADDR_W-1:1], burst_lsb};

  // R2: nothing is loaded on a second-beat edge
  a_r2_no_load_on_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q |=> ($stable(cmd_vld_q) && $stable(cmd_addr_q)));

  // R4: beat 1 stays in the pair and flips the low address bit
  a_r4_pair_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_q && cmd_vld_q) |=> (beat_vld
      && beat_addr[0] != $past(beat_addr[0])
      && beat_addr[ADDR_W-1:1] == $past(beat_addr[ADDR_W-1:1])));
endmodule

// File: rtl/b2_mem_array.sv
module b2_mem_array #(
  parameter int ADDR_W = 5,
  parameter int WORD_W = 18,
  parameter int BYTE_W = 9,
  localparam int NB    = WORD_W / BYTE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [NB-1:0]     wmask_n,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] merged;

  assign rdata = mem[addr];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign merged[g*BYTE_W +: BYTE_W] = wmask_n[g] ? rdata[g*BYTE_W +: BYTE_W]
                                                   : wdata[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= merged;
  end
endmodule

// File: rtl/b2_rd_out.sv
module b2_rd_out #(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_en,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] q_data,
  output logic              q_drive
);
  logic              drive_q, drive_d;
  logic [WORD_W-1:0] data_q, data_d;

  always_comb begin
    drive_d = beat_en;
    data_d  = beat_en ? rdata : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_q <= 1'b0;
    else        drive_q <= drive_d;
  end

  always_ff @(posedge clk) data_q <= data_d;

  assign q_data  = data_q;
  assign q_drive = drive_q;

  // R7: a read never shows fewer than two beats
  a_r7_two_beats: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_q) |=> drive_q);
endmodule

// File: rtl/burst2_sram.sv
module burst2_sram import burst2_pkg::*; #(
  parameter int ADDR_W = 5,
  parameter int WORD_W = 18,
  parameter int BYTE_W = 9,
  localparam int NB    = WORD_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] d,
  input  logic [NB-1:0]     bw_n,
  output logic [WORD_W-1:0] q,
  output logic              q_drive
);
  logic [1:0]        rst_pipe;
  logic              rst_s;
  logic              phase, beat_vld, beat_rd;
  logic [ADDR_W-1:0] beat_addr;
  logic [WORD_W-1:0] rdata, q_data;
  logic              we, rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  b2_cmd_pipe #(.ADDR_W(ADDR_W)) u_pipe (
    .clk(clk), .rst_n(rst_s), .load_n(load_n), .rd_wr(rd_wr), .addr(addr),
    .phase(phase), .beat_vld(beat_vld), .beat_rd(beat_rd), .beat_addr(beat_addr)
  );

  assign we    = beat_vld & ~beat_rd;
  assign rd_en = beat_vld &  beat_rd;

  b2_mem_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_mem (
    .clk(clk), .we(we), .addr(beat_addr), .wdata(d), .wmask_n(bw_n), .rdata(rdata)
  );

  b2_rd_out #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_s), .beat_en(rd_en), .rdata(rdata),
    .q_data(q_data), .q_drive(q_drive)
  );

  assign q = q_drive ? q_data : 'z;

  // R7: read beat 0 is on the bus from the second edge after the command
  a_r7_read_latency: assert property (@(posedge clk) disable iff (!rst_s)
    (!phase && !load_n && dir_e'(rd_wr) == DIR_READ) |=> ##2 q_drive);

  // R8: beats belonging to a write never drive the bus
  a_r8_write_floats: assert property (@(posedge clk) disable iff (!rst_s)
    (!phase && !load_n && dir_e'(rd_wr) == DIR_WRITE) |=> ##2 !q_drive);
endmodule

// File: tb/burst2_sram_bench.sv
module burst2_sram_bench;
  localparam int AW = 5;
  localparam int W  = 18;
  localparam int BW = 9;
  localparam int NB = W / BW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_n, rd_wr;
  logic [AW-1:0] addr;
  logic [W-1:0]  d;
  logic [NB-1:0] bw_n;
  wire  [W-1:0]  q;
  wire           q_drive;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [W-1:0] ref_mem [DEPTH];

  // pending command whose beats run during the current cycle
  logic          p_vld, p_rd;
  logic [AW-1:0] p_addr;
  logic [W-1:0]  p_d0, p_d1;
  logic [NB-1:0] p_m0, p_m1;

  always #10 clk = ~clk;

  burst2_sram #(.ADDR_W(AW), .WORD_W(W), .BYTE_W(BW)) u_burst2_sram (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .rd_wr(rd_wr), .addr(addr),
    .d(d), .bw_n(bw_n), .q(q), .q_drive(q_drive)
  );

  function automatic logic [W-1:0] merge(logic [W-1:0] old, logic [W-1:0] nw,
                                         logic [NB-1:0] mn);
    logic [W-1:0] r = old;
    for (int i = 0; i < NB; i++)
      if (!mn[i]) r[i*BW +: BW] = nw[i*BW +: BW];
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [W:0] act, logic [W:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R4, R7, R8: check one beat of the pending command; R5, R6: apply a write beat
  task automatic beat(int b, logic [W-1:0] bd, logic [NB-1:0] bm);
    logic [AW-1:0] wa = {p_addr[AW-1:1], p_addr[0] ^ b[0]};
    if (p_vld && p_rd)
      check(q_drive === 1'b1 && q === ref_mem[wa], "R4 R7 R9 read beat",
            {q_drive, q}, {1'b1, ref_mem[wa]});
    else
      check(q_drive === 1'b0, "R8 idle bus", {q_drive, q}, '0);
    if (p_vld && !p_rd) ref_mem[wa] = merge(ref_mem[wa], bd, bm);
  endtask

  // one command cycle: new command plus both beats of the previous one
  task automatic kcycle(bit ld, bit rw, logic [AW-1:0] a, logic [W-1:0] d0,
                        logic [W-1:0] d1, logic [NB-1:0] m0, logic [NB-1:0] m1);
    bit pw = p_vld && !p_rd;
    load_n = !ld; rd_wr = rw; addr = a;
    d    = pw ? p_d0 : W'($urandom);
    bw_n = pw ? p_m0 : NB'($urandom);
    @(posedge clk); @(negedge clk);
    beat(0, d, bw_n);
    // R2: junk strobe on the second-beat edge
    load_n = 1'($urandom); rd_wr = 1'($urandom); addr = AW'($urandom);
    d    = pw ? p_d1 : W'($urandom);
    bw_n = pw ? p_m1 : NB'($urandom);
    @(posedge clk); @(negedge clk);
    beat(1, d, bw_n);
    p_vld = ld; p_rd = rw; p_addr = a;
    p_d0 = d0; p_d1 = d1; p_m0 = m0; p_m1 = m1;
  endtask

  initial begin
    rst_n = 1'b0; load_n = 1'b1; rd_wr = 1'b0; addr = '0; d = '0; bw_n = '1;
    p_vld = 1'b0; p_rd = 1'b0; p_addr = '0;
    p_d0 = '0; p_d1 = '0; p_m0 = '1; p_m1 = '1;
    repeat (3) @(negedge clk);
    check(q_drive === 1'b0, "R1 reset", {q_drive, q}, '0);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(q_drive === 1'b0, "R1 after release", {q_drive, q}, '0);

    // R3 R5: fill every pair with full-word writes
    for (int a = 0; a < DEPTH; a += 2)
      kcycle(1, 0, AW'(a), W'(a * 1031 + 7), W'(a * 777 + 3), '0, '0);
    // R4: read back starting on the odd word so the counter wraps
    for (int a = 1; a < DEPTH; a += 2)
      kcycle(1, 1, AW'(a), '0, '0, '0, '0);
    // R6 R9: every mask pair followed straight away by a read of the same pair
    for (int m0 = 0; m0 < (1 << NB); m0++)
      for (int m1 = 0; m1 < (1 << NB); m1++) begin
        logic [AW-1:0] a = AW'(m0 * 4 + m1 * 2 + m1 % 2);
        kcycle(1, 0, a, W'($urandom), W'($urandom), NB'(m0), NB'(m1));
        kcycle(1, 1, a ^ AW'(1), '0, '0, '0, '0);
      end
    // R2 R9: random gapless traffic with idle cycles mixed in
    for (int i = 0; i < 1500; i++)
      kcycle(($urandom % 5) != 0, 1'($urandom), AW'($urandom),
             W'($urandom), W'($urandom), NB'($urandom), NB'($urandom));
    kcycle(0, 0, '0, '0, '0, '0, '0);
    kcycle(0, 0, '0, '0, '0, '0, '0);
    // R2: final sweep shows no junk strobe ever wrote memory
    for (int a = 0; a < DEPTH; a += 2)
      kcycle(1, 1, AW'(a), '0, '0, '0, '0);
    kcycle(0, 0, '0, '0, '0, '0, '0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule